// File: doc/BRIEF.md
# Speculative Trace Verification Engine

This block checks, in program order, the results that a speculative thread has already committed. It reads those results as entries from a look-ahead buffer and compares each one against the non-speculative architectural state, which is a small register file, a word memory and a program counter. Up to `LANES` entries are examined in one cycle. Register writes made by earlier lanes are forwarded to the source comparisons of later lanes in the same cycle.

A mismatch is repaired locally wherever possible, so that correctly executed work that does not depend on the mismatch is kept:
- Arithmetic entries are recomputed from the non-speculative operands.
- Load and store addresses are recomputed from the base register and the literal offset.
- Branches are judged only by their target.

An entry that cannot be repaired stops verification at that entry. The block then flushes the buffer and raises a synchronization request. For one cycle after that it accepts nothing, and then it returns to idle.

Top module: `trace_verify_engine`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: the program counter, every register, every memory word, `sync_req`, `br_mismatch` and `vfy_count`.
- R2: An arithmetic entry is ADD (op 0), SUB (1), AND (2) or XOR (3). If both of its recorded source values equal the non-speculative source registers, its recorded destination value is written to register `rd`, and the program counter becomes the entry's pc + 1.
- R3: An arithmetic entry with any source mismatch is re-executed on the non-speculative source values, and the computed result is committed to `rd`.
- R4: Entries are taken strictly in lane order, and only as a contiguous prefix of valid lanes. `lab_accept` gives the number of lanes taken. At most one entry per cycle may be repaired. A second entry that needs repair stops verification at that entry, and it is taken in a later cycle.
- R5: A register written by an earlier lane in a cycle is the value that later lanes in the same cycle compare against and compute with.
- R6: A store (op 5) writes the non-speculative value of register `rs2` to memory. The address is the recorded address when that address equals `rs1 + imm` (modulo the memory depth). Otherwise the address is the recomputed `rs1 + imm`, and the entry counts as a repair.
- R7: A load (op 4) writes into `rd` the non-speculative memory word found at `rs1 + imm`. When the recorded address differs from that value, the entry counts as a repair.
- R8: At most one load or store is taken per cycle. A second one stops verification at that entry.
- R9: A branch (op 6) computes its real target from the non-speculative `rs1`: pc + imm when `rs1` is non-zero, and pc + 1 otherwise. The recorded source values are ignored. When the real target equals the recorded destination value, the branch is taken and the program counter becomes that target.
- R10: When a branch target does not match, the following happens:
  - Earlier lanes of that cycle still commit, and the failing entry does not.
  - `lab_flush` is high in that cycle.
  - `sync_req` and `br_mismatch` are high in the next cycle.
- R11: A multi-cycle entry (MUL, op 7) commits its recorded destination value when its sources match. When its sources mismatch, it flushes the buffer and raises `sync_req`, and `br_mismatch` stays low.
- R12: In the cycle in which `sync_req` is high, no entry is taken.
- R13: `vfy_count` gives, one cycle later, the number of entries taken in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lab_valid | input | LANES | Valid mask of the entries offered this cycle, lane 0 oldest |
| lab_entries | input | LANES*84 | Lane i occupies bits [i*84 +: 84]. The fields are listed LSB first: pc[15:0], op[18:16], rs1[21:19], rs2[24:22], rd[27:25], v1[43:28], v2[59:44], vd[75:60], addr[79:76], imm[83:80] |
| lab_accept | output | $clog2(LANES+1) | Number of leading lanes taken this cycle |
| lab_flush | output | 1 | Drop all remaining buffer contents |
| sync_req | output | 1 | Synchronization request, one cycle after a flush |
| br_mismatch | output | 1 | The last synchronization was caused by a branch target mismatch |
| vfy_count | output | $clog2(LANES+1) | Entries taken in the previous cycle |
| arch_pc | output | 16 | Non-speculative program counter |
| arf_raddr | input | 3 | Register file read address |
| arf_rdata | output | 16 | Register file read data |
| mem_raddr | input | 4 | Memory read address |
| mem_rdata | output | 16 | Memory read data |

## Verification
`lab_accept` and `lab_flush` are combinational in the cycle in which the entries are offered. They are sampled one nanosecond after the inputs change, before the clock edge. The register file, the memory and `arch_pc` change at that edge, and so do `vfy_count`, `sync_req` and `br_mismatch`. Their checks are therefore made at the following falling edge, through the read ports. A scoreboard queue holds the expected count for each driven cycle and is compared with `vfy_count` one edge later. The halt cycle is checked by offering a valid entry while `sync_req` is high.

// File: rtl/tve_pkg.sv
// Shared widths, operation codes, the buffer entry layout and the re-execution ALU.
// Assumes a power-of-two memory depth, so address arithmetic simply wraps.
package tve_pkg;
    localparam int XLEN   = 16;
    localparam int NREG   = 8;
    localparam int RW     = $clog2(NREG);
    localparam int AW     = 4;
    localparam int MDEPTH = 1 << AW;

    typedef enum logic [2:0] {
        OP_ADD    = 3'd0,
        OP_SUB    = 3'd1,
        OP_AND    = 3'd2,
        OP_XOR    = 3'd3,
        OP_LOAD   = 3'd4,
        OP_STORE  = 3'd5,
        OP_BRANCH = 3'd6,
        OP_MUL    = 3'd7
    } op_e;

    typedef struct packed {
        logic [AW-1:0]   imm;
        logic [AW-1:0]   addr;
        logic [XLEN-1:0] vd;
        logic [XLEN-1:0] v2;
        logic [XLEN-1:0] v1;
        logic [RW-1:0]   rd;
        logic [RW-1:0]   rs2;
        logic [RW-1:0]   rs1;
        op_e             op;
        logic [XLEN-1:0] pc;
    } entry_t;

    localparam int EW = $bits(entry_t);

    // Single-cycle ALU used to re-execute arithmetic entries.
    function automatic logic [XLEN-1:0] alu_eval(op_e op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            OP_XOR:  return a ^ b;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/tve_arf.sv
// Non-speculative register file.
// It loads a complete next image every cycle, and it offers one combinational read port.
// Assumes that the caller presents the current image again when nothing is written.
module tve_arf
    import tve_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [XLEN-1:0] nxt_i [NREG],
    output logic [XLEN-1:0] cur_o [NREG],
    input  logic [RW-1:0]   raddr_i,
    output logic [XLEN-1:0] rdata_o
);
    // Register the next image; reset clears every register.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) cur_o[r] <= '0;
            else        cur_o[r] <= nxt_i[r];
        end
    end

    // External read port.
    assign rdata_o = cur_o[raddr_i];
endmodule

// File: rtl/tve_mem.sv
// Non-speculative data memory.
// It has one synchronous write port, and it exposes the whole array for same-cycle reads
// plus one external read port. Assumes at most one writer per cycle.
module tve_mem
    import tve_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [AW-1:0]   wa_i,
    input  logic [XLEN-1:0] wd_i,
    output logic [XLEN-1:0] img_o [MDEPTH],
    input  logic [AW-1:0]   raddr_i,
    output logic [XLEN-1:0] rdata_o
);
    // Write one word per cycle; reset clears the array.
    always_ff @(posedge clk) begin
        for (int w = 0; w < MDEPTH; w++) begin
            if (!rst_n)                            img_o[w] <= '0;
            else if (we_i && wa_i == AW'(w))       img_o[w] <= wd_i;
        end
    end

    // External read port.
    assign rdata_o = img_o[raddr_i];
endmodule

// File: rtl/tve_verify_core.sv
// Combinational verification of up to LANES buffer entries, handled in order.
// Each lane sees the register image as left by the lanes before it (forwarding).
// The lane walk stops at the first invalid lane, at a second repair, at a second memory
// entry, or at an unrepairable entry; an unrepairable entry also raises flush.
// Assumes that the caller gates valid_i while a synchronization is pending.
module tve_verify_core
    import tve_pkg::*;
#(
    parameter int LANES = 8,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] valid_i,
    input  entry_t           ent_i  [LANES],
    input  logic [XLEN-1:0]  regs_i [NREG],
    input  logic [XLEN-1:0]  mem_i  [MDEPTH],
    input  logic [XLEN-1:0]  pc_i,
    output logic [XLEN-1:0]  regs_o [NREG],
    output logic [XLEN-1:0]  pc_o,
    output logic [CW-1:0]    accept_o,
    output logic             flush_o,
    output logic             brmis_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_wa_o,
    output logic [XLEN-1:0]  mem_wd_o
);
    entry_t          e;
    logic [XLEN-1:0] s1, s2, tgt;
    logic [AW-1:0]   ea;
    logic            go, fixed, memd, take, srcs_ok, addr_ok;

    // Walk the lanes in order, committing, repairing or stopping.
    always_comb begin
        regs_o   = regs_i;
        pc_o     = pc_i;
        accept_o = '0;
        flush_o  = 1'b0;
        brmis_o  = 1'b0;
        mem_we_o = 1'b0;
        mem_wa_o = '0;
        mem_wd_o = '0;
        go       = 1'b1;
        fixed    = 1'b0;
        memd     = 1'b0;
        e        = '0;
        s1       = '0;
        s2       = '0;
        tgt      = '0;
        ea       = '0;
        take     = 1'b0;
        srcs_ok  = 1'b0;
        addr_ok  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            e       = ent_i[i];
            s1      = regs_o[e.rs1];
            s2      = regs_o[e.rs2];
            srcs_ok = (s1 == e.v1) && (s2 == e.v2);
            ea      = s1[AW-1:0] + e.imm;
            addr_ok = (ea == e.addr);
            tgt     = (s1 != '0) ? e.pc + XLEN'(e.imm) : e.pc + XLEN'(1);
            take    = 1'b0;
            if (go && valid_i[i]) begin
                case (e.op)
                    OP_ADD, OP_SUB, OP_AND, OP_XOR: begin
                        if (srcs_ok) begin
                            regs_o[e.rd] = e.vd;
                            take = 1'b1;
                        end else if (!fixed) begin
                            regs_o[e.rd] = alu_eval(e.op, s1, s2);
                            fixed = 1'b1;
                            take  = 1'b1;
                        end
                    end
                    OP_LOAD: begin
                        if (!memd && (addr_ok || !fixed)) begin
                            regs_o[e.rd] = mem_i[ea];
                            fixed = fixed | !addr_ok;
                            memd  = 1'b1;
                            take  = 1'b1;
                        end
                    end
                    OP_STORE: begin
                        if (!memd && (addr_ok || !fixed)) begin
                            mem_we_o = 1'b1;
                            mem_wa_o = ea;
                            mem_wd_o = s2;
                            fixed = fixed | !addr_ok;
                            memd  = 1'b1;
                            take  = 1'b1;
                        end
                    end
                    OP_BRANCH: begin
                        if (tgt == e.vd) take = 1'b1;
                        else begin
                            flush_o = 1'b1;
                            brmis_o = 1'b1;
                        end
                    end
                    default: begin
                        if (srcs_ok) begin
                            regs_o[e.rd] = e.vd;
                            take = 1'b1;
                        end else flush_o = 1'b1;
                    end
                endcase
                if (take) begin
                    pc_o     = (e.op == OP_BRANCH) ? tgt : e.pc + XLEN'(1);
                    accept_o = accept_o + CW'(1);
                end else begin
                    go = 1'b0;
                end
            end else begin
                go = 1'b0;
            end
        end
    end
endmodule

// File: rtl/trace_verify_engine.sv
// Top level of the speculative trace verification engine.
// It unpacks the lanes, holds the program counter and the synchronization state, and
// ties together the verify core, the register file and the memory.
// Assumes that lab_valid marks the offered entries as a prefix, lane 0 oldest.
module trace_verify_engine
    import tve_pkg::*;
#(
    parameter int LANES = 8,
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    lab_valid,
    input  logic [LANES*EW-1:0] lab_entries,
    output logic [CW-1:0]       lab_accept,
    output logic                lab_flush,
    output logic                sync_req,
    output logic                br_mismatch,
    output logic [CW-1:0]       vfy_count,
    output logic [XLEN-1:0]     arch_pc,
    input  logic [RW-1:0]       arf_raddr,
    output logic [XLEN-1:0]     arf_rdata,
    input  logic [AW-1:0]       mem_raddr,
    output logic [XLEN-1:0]     mem_rdata
);
    entry_t          ents     [LANES];
    logic [XLEN-1:0] regs_cur [NREG];
    logic [XLEN-1:0] regs_nxt [NREG];
    logic [XLEN-1:0] mem_img  [MDEPTH];
    logic [XLEN-1:0] pc_nxt;
    logic            brmis, mem_we;
    logic [AW-1:0]   mem_wa;
    logic [XLEN-1:0] mem_wd;
    logic [LANES-1:0] gated_valid;

    // Slice the flat entry bus into one entry per lane.
    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign ents[g] = entry_t'(lab_entries[g*EW +: EW]);
    end

    // Nothing is taken while a synchronization is being raised.
    assign gated_valid = sync_req ? '0 : lab_valid;

    tve_verify_core #(.LANES(LANES)) u_core (
        .valid_i (gated_valid),
        .ent_i   (ents),
        .regs_i  (regs_cur),
        .mem_i   (mem_img),
        .pc_i    (arch_pc),
        .regs_o  (regs_nxt),
        .pc_o    (pc_nxt),
        .accept_o(lab_accept),
        .flush_o (lab_flush),
        .brmis_o (brmis),
        .mem_we_o(mem_we),
        .mem_wa_o(mem_wa),
        .mem_wd_o(mem_wd)
    );

    tve_arf u_arf (
        .clk    (clk),
        .rst_n  (rst_n),
        .nxt_i  (regs_nxt),
        .cur_o  (regs_cur),
        .raddr_i(arf_raddr),
        .rdata_o(arf_rdata)
    );

    tve_mem u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (mem_we),
        .wa_i   (mem_wa),
        .wd_i   (mem_wd),
        .img_o  (mem_img),
        .raddr_i(mem_raddr),
        .rdata_o(mem_rdata)
    );

    // Program counter, synchronization flags and the count of verified entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arch_pc     <= '0;
            sync_req    <= 1'b0;
            br_mismatch <= 1'b0;
            vfy_count   <= '0;
        end else begin
            arch_pc     <= pc_nxt;
            sync_req    <= lab_flush;
            br_mismatch <= brmis;
            vfy_count   <= lab_accept;
        end
    end

    // R4
    accept_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(lab_accept) <= $countones(lab_valid));

    // R4
    lane0_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lab_accept != '0) |-> lab_valid[0]);

    // R12
    sync_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |-> (lab_accept == '0));

    // R2
    pc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lab_accept == '0) |=> $stable(arch_pc));

    // R10
    brmis_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_mismatch |-> sync_req);
endmodule

// File: tb/trace_verify_engine_test.sv
module trace_verify_engine_test;
    import tve_pkg::*;

    localparam int LANES = 8;
    localparam int CW    = $clog2(LANES + 1);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [LANES-1:0]    lab_valid = '0;
    logic [LANES*EW-1:0] lab_entries = '0;
    logic [CW-1:0]       lab_accept, vfy_count;
    logic                lab_flush, sync_req, br_mismatch;
    logic [XLEN-1:0]     arch_pc, arf_rdata, mem_rdata;
    logic [RW-1:0]       arf_raddr = '0;
    logic [AW-1:0]       mem_raddr = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit armed  = 0;
    int unsigned sb_q[$];

    trace_verify_engine #(.LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .lab_valid(lab_valid), .lab_entries(lab_entries),
        .lab_accept(lab_accept), .lab_flush(lab_flush), .sync_req(sync_req),
        .br_mismatch(br_mismatch), .vfy_count(vfy_count), .arch_pc(arch_pc),
        .arf_raddr(arf_raddr), .arf_rdata(arf_rdata),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    function automatic entry_t mk(int pc, op_e op, int rs1, int rs2, int rd,
                                  int v1, int v2, int vd, int addr, int imm);
        entry_t e;
        e.pc = XLEN'(pc); e.op = op; e.rs1 = RW'(rs1); e.rs2 = RW'(rs2); e.rd = RW'(rd);
        e.v1 = XLEN'(v1); e.v2 = XLEN'(v2); e.vd = XLEN'(vd);
        e.addr = AW'(addr); e.imm = AW'(imm);
        return e;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic put(int i, entry_t e);
        lab_entries[i*EW +: EW] = e;
        lab_valid[i] = 1'b1;
    endtask

    // Driver: checks the same-cycle handshake, queues the expected count, crosses one edge.
    task automatic step(int exp_acc, int exp_flush, string tag);
        #1;
        chk({tag, " accept"}, lab_accept, exp_acc);
        chk({tag, " flush"}, lab_flush, exp_flush);
        sb_q.push_back(exp_acc);
        @(posedge clk);
        @(negedge clk);
        lab_valid = '0;
        lab_entries = '0;
    endtask

    task automatic reg_is(int r, int exp, string tag);
        arf_raddr = RW'(r);
        #1;
        chk(tag, arf_rdata, exp);
    endtask

    task automatic mem_is(int a, int exp, string tag);
        mem_raddr = AW'(a);
        #1;
        chk(tag, mem_rdata, exp);
    endtask

    // Monitor: compares vfy_count with the count queued for the previous cycle (R13).
    always @(negedge clk) begin
        if (armed && sb_q.size() > 0) begin
            int unsigned exp_n;
            exp_n = sb_q.pop_front();
            chk("R13 vfy_count", vfy_count, exp_n);
        end
    end

    initial begin
        #(20 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1;
        // R1 reset state
        chk("R1 pc", arch_pc, 0);
        chk("R1 sync_req", sync_req, 0);
        chk("R1 br_mismatch", br_mismatch, 0);
        chk("R1 vfy_count", vfy_count, 0);
        reg_is(3, 0, "R1 reg3");
        mem_is(5, 0, "R1 mem5");

        // R2 + R5: a matched commit, then a dependent lane sees the forwarded value
        put(0, mk(0, OP_ADD, 0, 0, 1, 0, 0, 5, 0, 0));
        put(1, mk(1, OP_ADD, 1, 1, 2, 5, 5, 10, 0, 0));
        step(2, 0, "R2");
        reg_is(1, 5, "R2 r1 recorded");
        reg_is(2, 10, "R5 r2 forwarded");
        chk("R2 pc", arch_pc, 2);

        // R3 + R4: first repair is kept, second repair stops the walk
        put(0, mk(2, OP_ADD, 1, 2, 3, 7, 10, 99, 0, 0));
        put(1, mk(3, OP_SUB, 2, 1, 4, 0, 5, 0, 0, 0));
        put(2, mk(4, OP_ADD, 0, 0, 5, 0, 0, 1, 0, 0));
        step(1, 0, "R4 one repair");
        reg_is(3, 15, "R3 add recomputed");
        reg_is(4, 0, "R4 second repair held back");
        chk("R4 pc", arch_pc, 3);

        // R3 + R5: the held entry is repaired, and the next lane matches the repaired value
        put(0, mk(3, OP_SUB, 2, 1, 4, 0, 5, 0, 0, 0));
        put(1, mk(4, OP_AND, 4, 3, 6, 5, 15, 5, 0, 0));
        step(2, 0, "R3 retry");
        reg_is(4, 5, "R3 sub recomputed");
        reg_is(6, 5, "R5 forwarded repair");
        chk("R3 pc", arch_pc, 5);

        // R6 + R8: store with a good address; a second memory entry waits
        put(0, mk(5, OP_STORE, 0, 2, 0, 0, 0, 0, 3, 3));
        put(1, mk(6, OP_LOAD, 0, 0, 7, 0, 0, 0, 3, 3));
        step(1, 0, "R8 one memory op");
        mem_is(3, 10, "R6 store data from nonspec reg");
        reg_is(7, 0, "R8 load held back");

        // R7: load with a good address
        put(0, mk(6, OP_LOAD, 0, 0, 7, 0, 0, 0, 3, 3));
        step(1, 0, "R7");
        reg_is(7, 10, "R7 load value");

        // R6: store address recomputed as r1 + 2 = 7
        put(0, mk(7, OP_STORE, 1, 3, 0, 5, 15, 0, 9, 2));
        step(1, 0, "R6 repair");
        mem_is(7, 15, "R6 recomputed address");
        mem_is(9, 0, "R6 recorded address untouched");

        // R7: load address recomputed as 7
        put(0, mk(8, OP_LOAD, 1, 0, 6, 5, 0, 0, 0, 2));
        step(1, 0, "R7 repair");
        reg_is(6, 15, "R7 refetched value");
        chk("R7 pc", arch_pc, 9);

        // R9: taken branch with wrong recorded source, then a not-taken branch
        put(0, mk(9, OP_BRANCH, 1, 0, 0, 0, 0, 13, 0, 4));
        put(1, mk(13, OP_BRANCH, 0, 0, 0, 0, 0, 14, 0, 6));
        step(2, 0, "R9");
        chk("R9 pc", arch_pc, 14);

        // R10: earlier lane commits, mismatching branch flushes
        put(0, mk(14, OP_ADD, 0, 0, 1, 0, 0, 42, 0, 0));
        put(1, mk(15, OP_BRANCH, 2, 0, 0, 10, 0, 16, 0, 3));
        put(2, mk(16, OP_ADD, 0, 0, 5, 0, 0, 3, 0, 0));
        step(1, 1, "R10");
        reg_is(1, 42, "R10 earlier lane kept");
        reg_is(5, 0, "R10 later lane dropped");
        chk("R10 pc", arch_pc, 15);
        chk("R10 sync_req", sync_req, 1);
        chk("R10 br_mismatch", br_mismatch, 1);

        // R12: nothing is taken while sync_req is high
        put(0, mk(20, OP_ADD, 0, 0, 5, 0, 0, 9, 0, 0));
        step(0, 0, "R12");
        reg_is(5, 0, "R12 no commit");
        chk("R12 sync_req dropped", sync_req, 0);
        chk("R12 pc", arch_pc, 15);

        // R11: matched multi-cycle entry commits, mismatched one forces synchronization
        put(0, mk(20, OP_MUL, 1, 2, 7, 42, 10, 420, 0, 0));
        put(1, mk(21, OP_MUL, 1, 2, 5, 1, 10, 7, 0, 0));
        step(1, 1, "R11");
        reg_is(7, 420, "R11 recorded value");
        reg_is(5, 0, "R11 failed entry dropped");
        chk("R11 sync_req", sync_req, 1);
        chk("R11 br_mismatch", br_mismatch, 0);
        chk("R11 pc", arch_pc, 21);

        @(posedge clk);
        @(negedge clk);
        chk("R12 idle after sync", sync_req, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule